// File: doc/BRIEF.md
# RISC Instruction Decoder Unit

This block turns one 32-bit instruction word of a small load-store RISC subset into the control and operand fields that a multi-cycle datapath needs. It is purely combinational. A sequencer presents the fetched word on `instr`, and the decoded fields settle within the same cycle. The sequencer, the register file, the ALU and the memory port use those fields. The block holds no state and has no clock.

Three word layouts exist. In the register form the top six bits are zero and the operation sits in the low six bits. In the immediate form and the jump form the operation sits in the top six bits. The decoder places the register indices, and it extends the immediate as each operation requires: sign, zero, upper half, or 26-bit sign. It sends the store-data register out on the second source index. It steers link writes to register 31. Any word it does not recognise raises a flag and leaves every side effect off.

The house style asks for a state machine, but this block has no states. It keeps only the layout and the naming of that style: a shared package, one process per decode table, and 4-space indent.

Top module: `rdec_top`

## Requirements
- R1: `rs1_idx` is always bits 25:21 and `rs2_idx` is always bits 20:16. `rd_idx` is bits 15:11 for register-form words (bits 31:26 = 0) and bits 20:16 for immediate-form words.
- R2: Register-form function codes map to `alu_op` and set `reg_wr_en` = 1, `opb_is_imm` = 0 and `imm_val` = 0. The codes are 0x20 add (alu 0), 0x22 sub (1), 0x24 and (2), 0x25 or (3), 0x26 xor (4), 0x04 sll (5), 0x06 srl (6), 0x07 sra (7), 0x28 seq (8), 0x29 sne (9), 0x2a slt (10) and 0x2c sle (11).
- R3: Immediate-form ALU opcodes set `opb_is_imm` = 1 and `reg_wr_en` = 1, with `alu_op` following the R2 codes. The opcodes are 0x08 add, 0x0a sub, 0x0c and, 0x0d or, 0x0e xor, 0x14 sll, 0x16 srl, 0x17 sra, 0x18 seq, 0x19 sne, 0x1a slt and 0x1c sle.
- R4: Opcodes 0x08, 0x0a, 0x18, 0x19, 0x1a, 0x1c, 0x04, 0x05, 0x23 and 0x2b sign-extend bits 15:0 into `imm_val`.
- R5: Opcodes 0x0c, 0x0d, 0x0e, 0x14, 0x16 and 0x17 zero-extend bits 15:0 into `imm_val`.
- R6: Opcode 0x0f places bits 15:0 in the upper half of `imm_val` with zeros below. It sets `alu_op` = 12 (pass operand B), `opb_is_imm` = 1 and `reg_wr_en` = 1.
- R7: Opcode 0x23 sets `mem_rd` = 1 and `reg_wr_en` = 1. Opcode 0x2b sets `mem_wr` = 1 and `reg_wr_en` = 0, with its store-data register on `rs2_idx`. Both use `alu_op` = 0 and `opb_is_imm` = 1.
- R8: Opcode 0x04 sets `br_zero` and opcode 0x05 sets `br_nonzero`. Neither writes a register.
- R9: Opcodes 0x02 and 0x03 set `jmp_rel`, with `imm_val` = bits 25:0 sign-extended. Only 0x03 writes a register.
- R10: Opcodes 0x12 and 0x13 set `jmp_reg`, with `imm_val` = 0 and `opb_is_imm` = 0. Only 0x13 writes a register.
- R11: Opcodes 0x03 and 0x13 set `wr_link` = 1 and `reg_wr_en` = 1, and force `rd_idx` = 31. No other word sets `wr_link`.
- R12: Any other opcode, and any register-form function code not listed in R2, sets `bad_instr` = 1. It clears every write, memory, branch and jump output, and gives `alu_op` = 0 and `imm_val` = 0.
- R13: At most one of `mem_rd` and `mem_wr` is set. At most one of `br_zero`, `br_nonzero`, `jmp_rel` and `jmp_reg` is set. A store never writes a register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word to decode |
| rs1_idx | output | 5 | First source register index |
| rs2_idx | output | 5 | Second source (or store-data) register index |
| rd_idx | output | 5 | Destination register index |
| imm_val | output | 32 | Extended immediate |
| alu_op | output | 4 | ALU operation code |
| opb_is_imm | output | 1 | ALU operand B takes the immediate |
| reg_wr_en | output | 1 | Register write enable |
| wr_link | output | 1 | Write is a link to register 31 |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| br_zero | output | 1 | Branch if source is zero |
| br_nonzero | output | 1 | Branch if source is non-zero |
| jmp_rel | output | 1 | PC-relative jump |
| jmp_reg | output | 1 | Jump to register value |
| bad_instr | output | 1 | Unrecognised instruction |

## Verification
The assertions check on every settled input word the structural rules:
- an unrecognised word leaves every side effect off;
- memory strobes and control-transfer flags stay exclusive;
- a link always targets register 31;
- a store never writes;
- a register-form word never selects the immediate.

Only the bench scenarios can show that each code maps to the right ALU operation and the right extension, because those are value tables. The same holds for the corner where opcode 0x04 means a branch but function code 0x04 means a shift, and for the exact sign-extended widths.

// File: rtl/rdec_pkg.sv
package rdec_pkg;

    typedef enum logic [3:0] {
        ALU_ADD   = 4'd0,
        ALU_SUB   = 4'd1,
        ALU_AND   = 4'd2,
        ALU_OR    = 4'd3,
        ALU_XOR   = 4'd4,
        ALU_SLL   = 4'd5,
        ALU_SRL   = 4'd6,
        ALU_SRA   = 4'd7,
        ALU_SEQ   = 4'd8,
        ALU_SNE   = 4'd9,
        ALU_SLT   = 4'd10,
        ALU_SLE   = 4'd11,
        ALU_PASSB = 4'd12
    } alu_op_e;

    typedef enum logic [2:0] {
        IMM_NONE = 3'd0,
        IMM_SX16 = 3'd1,
        IMM_ZX16 = 3'd2,
        IMM_HI16 = 3'd3,
        IMM_SX26 = 3'd4
    } imm_kind_e;

    typedef struct packed {
        alu_op_e   alu;
        imm_kind_e ik;
        logic      opb_imm;
        logic      wr;
        logic      link;
        logic      rd_hi;
        logic      mrd;
        logic      mwr;
        logic      bz;
        logic      bnz;
        logic      jrel;
        logic      jreg;
        logic      bad;
    } ctrl_t;

    localparam int OPC_W  = 6;
    localparam int IMM_W  = 16;
    localparam int JOFF_W = 26;

endpackage

// File: rtl/rdec_fields.sv
module rdec_fields #(
    parameter int XLEN   = 32,
    parameter int RIDX_W = 5
) (
    input  logic [XLEN-1:0]              instr,
    output logic [rdec_pkg::OPC_W-1:0]   opcode,
    output logic [rdec_pkg::OPC_W-1:0]   func,
    output logic [RIDX_W-1:0]            f_rs1,
    output logic [RIDX_W-1:0]            f_rs2,
    output logic [RIDX_W-1:0]            f_rd_r,
    output logic [rdec_pkg::IMM_W-1:0]   f_imm16,
    output logic [rdec_pkg::JOFF_W-1:0]  f_off26
);
    localparam int OPC_LO = XLEN - rdec_pkg::OPC_W;
    localparam int RS1_LO = OPC_LO - RIDX_W;
    localparam int RS2_LO = RS1_LO - RIDX_W;
    localparam int RDR_LO = RS2_LO - RIDX_W;

    logic unused_shamt;

    assign opcode  = instr[XLEN-1:OPC_LO];
    assign func    = instr[rdec_pkg::OPC_W-1:0];
    assign f_rs1   = instr[OPC_LO-1:RS1_LO];
    assign f_rs2   = instr[RS1_LO-1:RS2_LO];
    assign f_rd_r  = instr[RS2_LO-1:RDR_LO];
    assign f_imm16 = instr[rdec_pkg::IMM_W-1:0];
    assign f_off26 = instr[rdec_pkg::JOFF_W-1:0];

    assign unused_shamt = ^instr[RDR_LO-1:rdec_pkg::OPC_W];
endmodule

// File: rtl/rdec_ctrl.sv
module rdec_ctrl
    import rdec_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    input  logic [OPC_W-1:0] func,
    output ctrl_t            ctrl
);
    ctrl_t c;

    always_comb begin
        c = '0;
        unique case (opcode)
            6'h00: begin
                c.wr = 1'b1;
                unique case (func)
                    6'h20:   c.alu = ALU_ADD;
                    6'h22:   c.alu = ALU_SUB;
                    6'h24:   c.alu = ALU_AND;
                    6'h25:   c.alu = ALU_OR;
                    6'h26:   c.alu = ALU_XOR;
                    6'h04:   c.alu = ALU_SLL;
                    6'h06:   c.alu = ALU_SRL;
                    6'h07:   c.alu = ALU_SRA;
                    6'h28:   c.alu = ALU_SEQ;
                    6'h29:   c.alu = ALU_SNE;
                    6'h2a:   c.alu = ALU_SLT;
                    6'h2c:   c.alu = ALU_SLE;
                    default: begin
                        c.wr  = 1'b0;
                        c.bad = 1'b1;
                    end
                endcase
            end
            6'h08, 6'h0a, 6'h18, 6'h19, 6'h1a, 6'h1c: begin
                c.opb_imm = 1'b1;
                c.wr      = 1'b1;
                c.rd_hi   = 1'b1;
                c.ik      = IMM_SX16;
                unique case (opcode)
                    6'h0a:   c.alu = ALU_SUB;
                    6'h18:   c.alu = ALU_SEQ;
                    6'h19:   c.alu = ALU_SNE;
                    6'h1a:   c.alu = ALU_SLT;
                    6'h1c:   c.alu = ALU_SLE;
                    default: c.alu = ALU_ADD;
                endcase
            end
            6'h0c, 6'h0d, 6'h0e, 6'h14, 6'h16, 6'h17: begin
                c.opb_imm = 1'b1;
                c.wr      = 1'b1;
                c.rd_hi   = 1'b1;
                c.ik      = IMM_ZX16;
                unique case (opcode)
                    6'h0c:   c.alu = ALU_AND;
                    6'h0d:   c.alu = ALU_OR;
                    6'h0e:   c.alu = ALU_XOR;
                    6'h14:   c.alu = ALU_SLL;
                    6'h16:   c.alu = ALU_SRL;
                    default: c.alu = ALU_SRA;
                endcase
            end
            6'h0f: begin
                c.opb_imm = 1'b1;
                c.wr      = 1'b1;
                c.rd_hi   = 1'b1;
                c.ik      = IMM_HI16;
                c.alu     = ALU_PASSB;
            end
            6'h23: begin
                c.opb_imm = 1'b1;
                c.wr      = 1'b1;
                c.rd_hi   = 1'b1;
                c.ik      = IMM_SX16;
                c.mrd     = 1'b1;
            end
            6'h2b: begin
                c.opb_imm = 1'b1;
                c.rd_hi   = 1'b1;
                c.ik      = IMM_SX16;
                c.mwr     = 1'b1;
            end
            6'h04, 6'h05: begin
                c.opb_imm = 1'b1;
                c.ik      = IMM_SX16;
                c.bz      = (opcode == 6'h04);
                c.bnz     = (opcode == 6'h05);
            end
            6'h02, 6'h03: begin
                c.opb_imm = 1'b1;
                c.ik      = IMM_SX26;
                c.jrel    = 1'b1;
                c.wr      = (opcode == 6'h03);
                c.link    = (opcode == 6'h03);
            end
            6'h12, 6'h13: begin
                c.jreg = 1'b1;
                c.wr   = (opcode == 6'h13);
                c.link = (opcode == 6'h13);
            end
            default: c.bad = 1'b1;
        endcase
    end

    assign ctrl = c;
endmodule

// File: rtl/rdec_immgen.sv
module rdec_immgen
    import rdec_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  imm_kind_e         kind,
    input  logic [IMM_W-1:0]  imm16,
    input  logic [JOFF_W-1:0] off26,
    output logic [XLEN-1:0]   imm_out
);
    localparam int PAD16 = XLEN - IMM_W;
    localparam int PAD26 = XLEN - JOFF_W;

    always_comb begin
        unique case (kind)
            IMM_SX16: imm_out = {{PAD16{imm16[IMM_W-1]}}, imm16};
            IMM_ZX16: imm_out = {{PAD16{1'b0}}, imm16};
            IMM_HI16: imm_out = XLEN'({imm16, {IMM_W{1'b0}}});
            IMM_SX26: imm_out = {{PAD26{off26[JOFF_W-1]}}, off26};
            default:  imm_out = '0;
        endcase
    end
endmodule

// File: rtl/rdec_top.sv
module rdec_top
    import rdec_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int RIDX_W   = 5,
    parameter int LINK_REG = 31
) (
    input  logic [XLEN-1:0]   instr,
    output logic [RIDX_W-1:0] rs1_idx,
    output logic [RIDX_W-1:0] rs2_idx,
    output logic [RIDX_W-1:0] rd_idx,
    output logic [XLEN-1:0]   imm_val,
    output logic [3:0]        alu_op,
    output logic              opb_is_imm,
    output logic              reg_wr_en,
    output logic              wr_link,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              br_zero,
    output logic              br_nonzero,
    output logic              jmp_rel,
    output logic              jmp_reg,
    output logic              bad_instr
);
    logic [OPC_W-1:0]  opcode;
    logic [OPC_W-1:0]  func;
    logic [RIDX_W-1:0] rd_r;
    logic [IMM_W-1:0]  imm16;
    logic [JOFF_W-1:0] off26;
    ctrl_t             ctrl;

    rdec_fields #(.XLEN(XLEN), .RIDX_W(RIDX_W)) u_fields (
        .instr   (instr),
        .opcode  (opcode),
        .func    (func),
        .f_rs1   (rs1_idx),
        .f_rs2   (rs2_idx),
        .f_rd_r  (rd_r),
        .f_imm16 (imm16),
        .f_off26 (off26)
    );

    rdec_ctrl u_ctrl (
        .opcode (opcode),
        .func   (func),
        .ctrl   (ctrl)
    );

    rdec_immgen #(.XLEN(XLEN)) u_imm (
        .kind    (ctrl.ik),
        .imm16   (imm16),
        .off26   (off26),
        .imm_out (imm_val)
    );

    always_comb begin
        if (ctrl.link)       rd_idx = RIDX_W'(LINK_REG);
        else if (ctrl.rd_hi) rd_idx = rs2_idx;
        else                 rd_idx = rd_r;
    end

    assign alu_op     = ctrl.alu;
    assign opb_is_imm = ctrl.opb_imm;
    assign reg_wr_en  = ctrl.wr;
    assign wr_link    = ctrl.link;
    assign mem_rd     = ctrl.mrd;
    assign mem_wr     = ctrl.mwr;
    assign br_zero    = ctrl.bz;
    assign br_nonzero = ctrl.bnz;
    assign jmp_rel    = ctrl.jrel;
    assign jmp_reg    = ctrl.jreg;
    assign bad_instr  = ctrl.bad;
endmodule

// File: rtl/rdec_chk.sv
module rdec_chk #(
    parameter int XLEN     = 32,
    parameter int RIDX_W   = 5,
    parameter int LINK_REG = 31
) (
    input logic [XLEN-1:0]   instr,
    input logic [RIDX_W-1:0] rd_idx,
    input logic              opb_is_imm,
    input logic              reg_wr_en,
    input logic              wr_link,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              br_zero,
    input logic              br_nonzero,
    input logic              jmp_rel,
    input logic              jmp_reg,
    input logic              bad_instr
);
    always_comb begin
        if (!$isunknown(instr)) begin
            a_r12_illegal_quiet: assert (!bad_instr ||
                !(reg_wr_en || wr_link || mem_rd || mem_wr ||
                  br_zero || br_nonzero || jmp_rel || jmp_reg));
            a_r13_mem_excl: assert (!(mem_rd && mem_wr));
            a_r13_xfer_onehot: assert ($onehot0({br_zero, br_nonzero, jmp_rel, jmp_reg}));
            a_r13_store_no_write: assert (!mem_wr || !reg_wr_en);
            a_r11_link_dest: assert (!wr_link ||
                (reg_wr_en && rd_idx == RIDX_W'(LINK_REG)));
            a_r2_rform_regb: assert ((instr[XLEN-1:XLEN-6] != 6'h00) || !opb_is_imm);
        end
    end
endmodule

bind rdec_top rdec_chk #(.XLEN(XLEN), .RIDX_W(RIDX_W), .LINK_REG(LINK_REG)) u_chk (.*);

// File: tb/rdec_top_test.sv
`timescale 1ns/1ps
module rdec_top_test;
    localparam int WDOG = 100000;

    logic        clk = 1'b0;
    logic [31:0] instr;
    logic [4:0]  rs1_idx, rs2_idx, rd_idx;
    logic [31:0] imm_val;
    logic [3:0]  alu_op;
    logic opb_is_imm, reg_wr_en, wr_link, mem_rd, mem_wr;
    logic br_zero, br_nonzero, jmp_rel, jmp_reg, bad_instr;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    // flag vector order: opb, wr, link, mrd, mwr, bz, bnz, jrel, jreg, bad
    localparam logic [9:0] F_OPB  = 10'b1000000000;
    localparam logic [9:0] F_WR   = 10'b0100000000;
    localparam logic [9:0] F_LINK = 10'b0010000000;
    localparam logic [9:0] F_MRD  = 10'b0001000000;
    localparam logic [9:0] F_MWR  = 10'b0000100000;
    localparam logic [9:0] F_BZ   = 10'b0000010000;
    localparam logic [9:0] F_BNZ  = 10'b0000001000;
    localparam logic [9:0] F_JREL = 10'b0000000100;
    localparam logic [9:0] F_JREG = 10'b0000000010;
    localparam logic [9:0] F_BAD  = 10'b0000000001;

    always #4 clk = ~clk;

    rdec_top uut (
        .instr(instr), .rs1_idx(rs1_idx), .rs2_idx(rs2_idx), .rd_idx(rd_idx),
        .imm_val(imm_val), .alu_op(alu_op), .opb_is_imm(opb_is_imm),
        .reg_wr_en(reg_wr_en), .wr_link(wr_link), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .br_zero(br_zero), .br_nonzero(br_nonzero), .jmp_rel(jmp_rel),
        .jmp_reg(jmp_reg), .bad_instr(bad_instr)
    );

    function automatic logic [31:0] rw(input logic [5:0] fn, input logic [4:0] a,
                                       input logic [4:0] b, input logic [4:0] d);
        return {6'h00, a, b, d, 5'h00, fn};
    endfunction

    function automatic logic [31:0] iw(input logic [5:0] op, input logic [4:0] a,
                                       input logic [4:0] d, input logic [15:0] im);
        return {op, a, d, im};
    endfunction

    function automatic logic [31:0] jw(input logic [5:0] op, input logic [25:0] v);
        return {op, v};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] w);
        @(negedge clk);
        instr = w;
        #1;
    endtask

    task automatic expect_dec(input string req, input logic [3:0] alu,
                              input logic [9:0] fl, input logic [31:0] imm, input int rd);
        chk(req, "alu_op", 32'(alu_op), 32'(alu));
        chk(req, "flags", 32'({opb_is_imm, reg_wr_en, wr_link, mem_rd, mem_wr,
                               br_zero, br_nonzero, jmp_rel, jmp_reg, bad_instr}), 32'(fl));
        chk(req, "imm_val", imm_val, imm);
        if (rd >= 0) chk(req, "rd_idx", 32'(rd_idx), 32'(rd));
    endtask

    task automatic t_reset_state;
        apply(32'h0000_0000);  // R12: all-zero word is an unknown function code
        expect_dec("R12", 4'd0, F_BAD, 32'h0, -1);
    endtask

    task automatic t_fields;
        apply(rw(6'h20, 5'd17, 5'd9, 5'd22));
        chk("R1", "rs1", 32'(rs1_idx), 32'd17);
        chk("R1", "rs2", 32'(rs2_idx), 32'd9);
        chk("R1", "rd r-form", 32'(rd_idx), 32'd22);
        apply(iw(6'h08, 5'd3, 5'd30, 16'h0005));
        chk("R1", "rs1 i-form", 32'(rs1_idx), 32'd3);
        chk("R1", "rd i-form", 32'(rd_idx), 32'd30);
    endtask

    task automatic t_rform;
        logic [5:0] fns [12] = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h26, 6'h04,
                                 6'h06, 6'h07, 6'h28, 6'h29, 6'h2a, 6'h2c};
        for (int i = 0; i < 12; i++) begin
            apply(rw(fns[i], 5'd1, 5'd2, 5'd7) | 32'h0000_07c0);  // R2: bits 10:6 ignored
            expect_dec("R2", 4'(i), F_WR, 32'h0, 7);
        end
    endtask

    task automatic t_iform;
        logic [5:0] sops [6] = '{6'h08, 6'h0a, 6'h18, 6'h19, 6'h1a, 6'h1c};
        logic [3:0] salu [6] = '{4'd0, 4'd1, 4'd8, 4'd9, 4'd10, 4'd11};
        logic [5:0] zops [6] = '{6'h0c, 6'h0d, 6'h0e, 6'h14, 6'h16, 6'h17};
        logic [3:0] zalu [6] = '{4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7};
        for (int i = 0; i < 6; i++) begin
            apply(iw(sops[i], 5'd5, 5'd9, 16'h8001));
            expect_dec("R3 R4", salu[i], F_OPB | F_WR, 32'hFFFF_8001, 9);
            apply(iw(sops[i], 5'd5, 5'd9, 16'h7ffe));
            chk("R4", "positive sext", imm_val, 32'h0000_7ffe);
        end
        for (int i = 0; i < 6; i++) begin
            apply(iw(zops[i], 5'd5, 5'd12, 16'h8001));
            expect_dec("R3 R5", zalu[i], F_OPB | F_WR, 32'h0000_8001, 12);
        end
    endtask

    task automatic t_upper;
        apply(iw(6'h0f, 5'd0, 5'd1, 16'h1234));
        expect_dec("R6", 4'd12, F_OPB | F_WR, 32'h1234_0000, 1);
        apply(iw(6'h0f, 5'd0, 5'd1, 16'hffff));
        chk("R6", "upper all ones", imm_val, 32'hFFFF_0000);
    endtask

    task automatic t_mem;
        apply(iw(6'h23, 5'd4, 5'd11, 16'hfffc));
        expect_dec("R7 load", 4'd0, F_OPB | F_WR | F_MRD, 32'hFFFF_FFFC, 11);
        apply(iw(6'h2b, 5'd2, 5'd6, 16'h0010));
        expect_dec("R7 store", 4'd0, F_OPB | F_MWR, 32'h0000_0010, -1);
        chk("R7", "store data idx", 32'(rs2_idx), 32'd6);
    endtask

    task automatic t_branch;
        apply(iw(6'h04, 5'd8, 5'd0, 16'hfff0));  // opcode 4 is a branch, not a shift
        expect_dec("R8 beqz", 4'd0, F_OPB | F_BZ, 32'hFFFF_FFF0, -1);
        apply(iw(6'h05, 5'd8, 5'd0, 16'h0020));
        expect_dec("R8 bnez", 4'd0, F_OPB | F_BNZ, 32'h0000_0020, -1);
    endtask

    task automatic t_jump;
        apply(jw(6'h02, 26'h200_0000));
        expect_dec("R9 j", 4'd0, F_OPB | F_JREL, 32'hFE00_0000, -1);
        apply(jw(6'h02, 26'h1ff_ffff));
        chk("R9", "j positive", imm_val, 32'h01FF_FFFF);
        apply(jw(6'h03, 26'h3ff_fff8));
        expect_dec("R9 R11 jal", 4'd0, F_OPB | F_JREL | F_WR | F_LINK, 32'hFFFF_FFF8, 31);
        apply(iw(6'h12, 5'd8, 5'd3, 16'h7777));
        expect_dec("R10 jr", 4'd0, F_JREG, 32'h0, -1);
        chk("R10", "jr rs1", 32'(rs1_idx), 32'd8);
        apply(iw(6'h13, 5'd8, 5'd3, 16'h7777));
        expect_dec("R10 R11 jalr", 4'd0, F_JREG | F_WR | F_LINK, 32'h0, 31);
    endtask

    task automatic t_illegal;
        logic [5:0] bops [4] = '{6'h01, 6'h3f, 6'h09, 6'h2f};
        logic [5:0] bfns [3] = '{6'h05, 6'h21, 6'h3f};
        for (int i = 0; i < 4; i++) begin
            apply(iw(bops[i], 5'd1, 5'd2, 16'hffff));
            expect_dec("R12 opcode", 4'd0, F_BAD, 32'h0, -1);
        end
        for (int i = 0; i < 3; i++) begin
            apply(rw(bfns[i], 5'd1, 5'd2, 5'd3));
            expect_dec("R12 func", 4'd0, F_BAD, 32'h0, -1);
        end
    endtask

    task automatic finish_run;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WDOG) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected under %0d", cyc, WDOG);
            finish_run();
        end
    end

    initial begin
        instr = 32'h0;
        repeat (2) @(posedge clk);
        t_reset_state();
        t_fields();
        t_rform();
        t_iform();
        t_upper();
        t_mem();
        t_branch();
        t_jump();
        t_illegal();
        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule